// File: doc/BRIEF.md
# Configuration Request Packet Builder

This block takes one configuration-space access at a time (read or write, target bus, device/function, register offset, access width and write data) and turns it into a three-dword configuration request packet. The packet leaves on a 64-bit beat stream with a valid/ready handshake. Each beat carries two 32-bit words, low word first, and the first and last beats are flagged. The block chooses between the local-segment and the forwarded request type by comparing the target bus with a root bus number it holds. Byte enables and the data lane come from the low offset bits.

Before anything is sent, a request passes a set of access rules. The bridge's own first base address register is hidden. Only device 0 is reachable on the root bus. Downstream buses are unreachable while the link is not in its active state. A refused request sends nothing and produces a one-cycle response with an error code. A write to the primary-bus register of the root bus loads the root bus number from the low byte of the written value. This keeps later packets consistent with enumeration.

Top module: `cfg_tlp_packer`

## Requirements
- R1: After reset, req_ready is 1, tx_valid is 0, rsp_valid is 0 and root_bus is 0.
- R2: Header word 0 has the kind byte in bits [31:24]: 0x04 for a read and 0x44 for a write when the target bus equals root_bus, and 0x05 for a read and 0x45 for a write otherwise. Bits [9:0] hold a length of 1 and bits [23:10] are zero.
- R3: Header word 1 holds {root_bus, 8'h00} in bits [31:16], the tag in bits [15:8] (0x1D for reads, 0x10 for writes) and the 8-bit byte-enable field in bits [7:0].
- R4: Header word 2 holds the bus in bits [31:24], devfn in bits [23:16] and the offset with its two low bits cleared in bits [15:0].
- R5: req_size 2'b00 selects a byte access, with enables 0x01 shifted left by offset[1:0] and data (wdata & 0xFF) shifted left by 8*offset[1:0]. 2'b01 selects a 16-bit access, with enables 0x03 shifted left by offset[1:0] and data (wdata & 0xFFFF) shifted the same way. 2'b10 and 2'b11 select a 32-bit access, with enables 0x0F and the data unshifted.
- R6: A read is two beats. The first beat is {word1, word0} with tx_sop set. The second beat is {32'h0, word2} with tx_eop set. tx_data[31:0] is the first word of a beat.
- R7: A write whose offset[2:0] is 0 is three beats: {word1, word0} with tx_sop, then {32'h0, word2}, then {32'h0, data} with tx_eop.
- R8: A write whose offset[2:0] is not 0 is two beats: {word1, word0} with tx_sop, then {data, word2} with tx_eop.
- R9: A request to bus == root_bus, devfn 0, offset 0x10 sends no beat. In the cycle after acceptance it gives rsp_valid with rsp_code 2'b01.
- R10: A request to bus == root_bus with devfn[7:3] not zero sends no beat. In the cycle after acceptance it gives rsp_valid with rsp_code 2'b10. Other functions of device 0 are accepted.
- R11: While link_l0 is 0, a request to any bus other than root_bus sends no beat and gives rsp_valid with rsp_code 2'b10 in the cycle after acceptance. Requests to the root bus are unaffected.
- R12: A write to bus == root_bus at offset 0x18 loads root_bus with wdata[7:0] on the clock edge that transfers its last beat. A write to offset 0x18 on any other bus leaves root_bus unchanged.
- R13: req_ready is 1 only when no packet is in flight. While tx_valid is 1 and tx_ready is 0, tx_data, tx_sop and tx_eop hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device (bits 7:3) and function (bits 2:0) |
| req_offset | input | 12 | Register byte offset |
| req_size | input | 2 | Access width code (see R5) |
| req_wdata | input | 32 | Write value, right-aligned |
| link_l0 | input | 1 | Link is in the active state |
| tx_valid | output | 1 | Beat present |
| tx_ready | input | 1 | Sink takes the beat |
| tx_data | output | 64 | Beat, first word in bits 31:0 |
| tx_sop | output | 1 | First beat of a packet |
| tx_eop | output | 1 | Last beat of a packet |
| rsp_valid | output | 1 | Refusal response, one cycle |
| rsp_code | output | 2 | 2'b01 hidden register, 2'b10 no device |
| root_bus | output | 8 | Current root bus number |

## Verification
A wrong root bus number shows up in the first beat of the next packet: the kind byte flips between local and forwarded, and the requester field in bits [31:16] of word 1 is wrong. The same fault also moves the accept/refuse boundary, so a wrong value is visible within one request. A sequencer state error shows as a missing or extra beat, or a misplaced end flag, on the packet in flight. A filter fault shows as a beat where a response was due, or the reverse, one cycle after acceptance.

// File: rtl/cfg_tlp_pkg.sv
// Shared constants and types for the configuration request packet builder.
// Assumes 32-bit header words and 8-bit bus and devfn numbers.
package cfg_tlp_pkg;

    localparam logic [7:0] KIND_RD_LOCAL = 8'h04;
    localparam logic [7:0] KIND_WR_LOCAL = 8'h44;
    localparam logic [7:0] KIND_RD_FWD   = 8'h05;
    localparam logic [7:0] KIND_WR_FWD   = 8'h45;
    localparam logic [7:0] TAG_READ      = 8'h1D;
    localparam logic [7:0] TAG_WRITE     = 8'h10;
    localparam logic [9:0] LEN_ONE       = 10'd1;

    typedef enum logic [1:0] {
        RSP_OK     = 2'b00,
        RSP_HIDDEN = 2'b01,
        RSP_NODEV  = 2'b10
    } rsp_code_e;

    // One fully formed packet, captured at acceptance.
    typedef struct packed {
        logic [31:0] w0;
        logic [31:0] w1;
        logic [31:0] w2;
        logic [31:0] data;
        logic        write;
        logic        qw_aligned;
        logic        root_upd;
        logic [7:0]  root_new;
    } tlp_job_t;

endpackage

// File: rtl/cfg_req_filter.sv
// Access rules applied before a request is packed.
// Purely combinational. Assumes root_bus is the current root bus number.
module cfg_req_filter
    import cfg_tlp_pkg::*;
#(
    parameter int OFF_W   = 12,
    parameter int BAR0_OFF = 16
) (
    input  logic [7:0]       bus,
    input  logic [7:0]       devfn,
    input  logic [OFF_W-1:0] offset,
    input  logic             link_l0,
    input  logic [7:0]       root_bus,
    output logic             reject,
    output rsp_code_e        code
);
    localparam logic [OFF_W-1:0] HIDE_OFF = OFF_W'(BAR0_OFF);

    logic on_root;

    // Decide refusal and its code; the hidden register takes priority.
    always_comb begin
        on_root = (bus == root_bus);
        reject  = 1'b0;
        code    = RSP_OK;
        if (on_root && devfn == 8'h00 && offset == HIDE_OFF) begin
            reject = 1'b1;
            code   = RSP_HIDDEN;
        end else if (!on_root && !link_l0) begin
            reject = 1'b1;
            code   = RSP_NODEV;
        end else if (on_root && devfn[7:3] != 5'd0) begin
            reject = 1'b1;
            code   = RSP_NODEV;
        end
    end

endmodule

// File: rtl/cfg_hdr_build.sv
// Builds the three header words, the lane-shifted data word and the
// sequencing hints for one request. Purely combinational.
// Assumes OFF_W is at most 16.
module cfg_hdr_build
    import cfg_tlp_pkg::*;
#(
    parameter int          OFF_W    = 12,
    parameter logic [7:0]  RP_DEVFN = 8'h00,
    parameter int          PRI_OFF  = 24
) (
    input  logic             write,
    input  logic [7:0]       bus,
    input  logic [7:0]       devfn,
    input  logic [OFF_W-1:0] offset,
    input  logic [1:0]       size,
    input  logic [31:0]      wdata,
    input  logic [7:0]       root_bus,
    output tlp_job_t         job
);
    localparam logic [OFF_W-1:0] PRI_BUS_OFF = OFF_W'(PRI_OFF);

    logic [1:0]  lane;
    logic [7:0]  be;
    logic [31:0] lane_data;
    logic [15:0] off16;
    logic        local_seg;
    logic [7:0]  kind;

    // Byte enables and data lane placement from width and low offset bits.
    always_comb begin
        lane = offset[1:0];
        case (size)
            2'b00: begin
                be        = 8'h01 << lane;
                lane_data = (wdata & 32'h0000_00FF) << {lane, 3'b000};
            end
            2'b01: begin
                be        = 8'h03 << lane;
                lane_data = (wdata & 32'h0000_FFFF) << {lane, 3'b000};
            end
            default: begin
                be        = 8'h0F;
                lane_data = wdata;
            end
        endcase
    end

    // Request kind from direction and whether the target is the root bus.
    always_comb begin
        local_seg = (bus == root_bus);
        if (write) kind = local_seg ? KIND_WR_LOCAL : KIND_WR_FWD;
        else       kind = local_seg ? KIND_RD_LOCAL : KIND_RD_FWD;
    end

    // Assemble header words and sequencing hints.
    always_comb begin
        off16              = '0;
        off16[OFF_W-1:0]   = {offset[OFF_W-1:2], 2'b00};
        job.w0             = {kind, 14'd0, LEN_ONE};
        job.w1             = {root_bus, RP_DEVFN, (write ? TAG_WRITE : TAG_READ), be};
        job.w2             = {bus, devfn, off16};
        job.data           = write ? lane_data : 32'h0;
        job.write          = write;
        job.qw_aligned     = (offset[2:0] == 3'b000);
        job.root_upd       = write && local_seg && (offset == PRI_BUS_OFF);
        job.root_new       = wdata[7:0];
    end

endmodule

// File: rtl/cfg_beat_seq.sv
// Holds one packed request and plays it out as two or three 64-bit beats.
// Assumes start is raised only while idle is high.
module cfg_beat_seq
    import cfg_tlp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  tlp_job_t    job_in,
    input  logic        tx_ready,
    output logic        idle,
    output logic        tx_valid,
    output logic [63:0] tx_data,
    output logic        tx_sop,
    output logic        tx_eop,
    output logic        done,
    output tlp_job_t    job_q
);
    typedef enum logic [1:0] {S_IDLE, S_HEAD, S_MID, S_TAIL} seq_state_e;

    seq_state_e state, state_nx;
    logic       three_beat;

    assign three_beat = job_q.write && job_q.qw_aligned;

    // Next-state choice for the beat sequence.
    always_comb begin
        state_nx = state;
        case (state)
            S_IDLE: if (start) state_nx = S_HEAD;
            S_HEAD: if (tx_ready) state_nx = S_MID;
            S_MID:  if (tx_ready) state_nx = three_beat ? S_TAIL : S_IDLE;
            S_TAIL: if (tx_ready) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Capture the packet when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)     job_q <= '0;
        else if (start) job_q <= job_in;
    end

    // Beat contents and flags for the current state.
    always_comb begin
        tx_data = 64'h0;
        tx_sop  = 1'b0;
        tx_eop  = 1'b0;
        case (state)
            S_HEAD: begin
                tx_data = {job_q.w1, job_q.w0};
                tx_sop  = 1'b1;
            end
            S_MID: begin
                tx_data = (job_q.write && !job_q.qw_aligned) ?
                          {job_q.data, job_q.w2} : {32'h0, job_q.w2};
                tx_eop  = !three_beat;
            end
            S_TAIL: begin
                tx_data = {32'h0, job_q.data};
                tx_eop  = 1'b1;
            end
            default: ;
        endcase
    end

    assign idle     = (state == S_IDLE);
    assign tx_valid = !idle;
    assign done     = tx_valid && tx_ready && tx_eop;

endmodule

// File: rtl/cfg_rootbus_trk.sv
// Root bus number register, loaded from a snooped primary-bus write.
// Assumes upd_en pulses once per completed qualifying write.
module cfg_rootbus_trk (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_en,
    input  logic [7:0] upd_val,
    output logic [7:0] root_bus
);
    // Hold the root bus number; cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      root_bus <= 8'h00;
        else if (upd_en) root_bus <= upd_val;
    end

endmodule

// File: rtl/cfg_tlp_packer.sv
// Top: accepts one configuration request at a time, filters it, packs it
// and streams it out; refusals come back on the response port.
// Assumes the sink may stall any beat through tx_ready.
module cfg_tlp_packer
    import cfg_tlp_pkg::*;
#(
    parameter int         OFF_W    = 12,
    parameter logic [7:0] RP_DEVFN = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [7:0]       req_bus,
    input  logic [7:0]       req_devfn,
    input  logic [OFF_W-1:0] req_offset,
    input  logic [1:0]       req_size,
    input  logic [31:0]      req_wdata,
    input  logic             link_l0,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [63:0]      tx_data,
    output logic             tx_sop,
    output logic             tx_eop,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code,
    output logic [7:0]       root_bus
);
    logic      accept, reject, start, seq_idle, seq_done;
    rsp_code_e flt_code;
    tlp_job_t  job_new, job_cur;

    cfg_req_filter #(.OFF_W(OFF_W)) u_filter (
        .bus      (req_bus),
        .devfn    (req_devfn),
        .offset   (req_offset),
        .link_l0  (link_l0),
        .root_bus (root_bus),
        .reject   (reject),
        .code     (flt_code)
    );

    cfg_hdr_build #(.OFF_W(OFF_W), .RP_DEVFN(RP_DEVFN)) u_hdr (
        .write    (req_write),
        .bus      (req_bus),
        .devfn    (req_devfn),
        .offset   (req_offset),
        .size     (req_size),
        .wdata    (req_wdata),
        .root_bus (root_bus),
        .job      (job_new)
    );

    cfg_beat_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .job_in   (job_new),
        .tx_ready (tx_ready),
        .idle     (seq_idle),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_sop   (tx_sop),
        .tx_eop   (tx_eop),
        .done     (seq_done),
        .job_q    (job_cur)
    );

    cfg_rootbus_trk u_root (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (seq_done && job_cur.root_upd),
        .upd_val  (job_cur.root_new),
        .root_bus (root_bus)
    );

    assign req_ready = seq_idle;
    assign accept    = req_valid && req_ready;
    assign start     = accept && !reject;

    // Refusal response, one cycle after the request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_OK;
        end else begin
            rsp_valid <= accept && reject;
            if (accept && reject) rsp_code <= flt_code;
        end
    end

endmodule

// File: rtl/cfg_tlp_packer_chk.sv
// Port-level properties of the packet builder, bound to the top module.
module cfg_tlp_packer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [63:0] tx_data,
    input logic        tx_sop,
    input logic        tx_eop,
    input logic        rsp_valid,
    input logic [7:0]  root_bus
);
    // R13
    idle_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && tx_valid));

    // R13
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

    // R6
    one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !(tx_sop && tx_eop));

    // R2
    head_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_sop) |-> (tx_data[23:0] == 24'h000001));

    // R9
    rsp_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) && !tx_valid));

    // R12
    root_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(root_bus) |-> $past(tx_valid && tx_ready && tx_eop));

endmodule

bind cfg_tlp_packer cfg_tlp_packer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_sop    (tx_sop),
    .tx_eop    (tx_eop),
    .rsp_valid (rsp_valid),
    .root_bus  (root_bus)
);

// File: tb/cfg_tlp_packer_tb.sv
// Directed bench for the packet builder: one task per scenario.
module cfg_tlp_packer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = 8'h00;
    logic [7:0]  req_devfn = 8'h00;
    logic [11:0] req_offset = 12'h000;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_wdata = 32'h0;
    logic        link_l0 = 1'b0;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [63:0] tx_data;
    logic        tx_sop;
    logic        tx_eop;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [7:0]  root_bus;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cfg_tlp_packer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bus(req_bus), .req_devfn(req_devfn),
        .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
        .link_l0(link_l0), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .root_bus(root_bus)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one request for one cycle; it is taken on the next rising edge.
    task automatic issue(input bit wr, input logic [7:0] bus, input logic [7:0] dfn,
                         input logic [11:0] off, input logic [1:0] sz, input logic [31:0] wd);
        @(negedge clk);
        check(req_ready == 1'b1, "R13 ready before request", {63'd0, req_ready}, 64'd1);
        req_write = wr; req_bus = bus; req_devfn = dfn;
        req_offset = off; req_size = sz; req_wdata = wd; req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // Check the beat offered in the current cycle (taken at the next edge).
    task automatic expect_beat(input string req, input logic [63:0] exp, input bit sop, input bit eop);
        @(negedge clk);
        check(tx_valid == 1'b1, {req, " valid"}, {63'd0, tx_valid}, 64'd1);
        check(tx_data == exp, {req, " data"}, tx_data, exp);
        check(tx_sop == sop && tx_eop == eop, {req, " flags"}, {62'd0, tx_sop, tx_eop}, {62'd0, sop, eop});
    endtask

    task automatic expect_idle(input string req);
        @(negedge clk);
        check(tx_valid == 1'b0 && req_ready == 1'b1, {req, " idle after packet"},
              {62'd0, tx_valid, req_ready}, 64'd1);
    endtask

    task automatic expect_refusal(input string req, input logic [1:0] code);
        @(negedge clk);
        check(rsp_valid == 1'b1 && rsp_code == code, {req, " refusal code"},
              {61'd0, rsp_valid, rsp_code}, {61'd0, 1'b1, code});
        check(tx_valid == 1'b0, {req, " nothing sent"}, {63'd0, tx_valid}, 64'd0);
        @(negedge clk);
        check(rsp_valid == 1'b0 && tx_valid == 1'b0, {req, " single pulse"},
              {62'd0, rsp_valid, tx_valid}, 64'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(req_ready == 1'b1 && tx_valid == 1'b0 && rsp_valid == 1'b0,
              "R1 reset outputs", {61'd0, req_ready, tx_valid, rsp_valid}, 64'd4);
        check(root_bus == 8'h00, "R1 root bus", {56'd0, root_bus}, 64'd0);
    endtask

    task automatic t_read_local;
        // R2 R3 R4 R6: dword read, bus 0 devfn 0 offset 0x08
        issue(1'b0, 8'h00, 8'h00, 12'h008, 2'b10, 32'h0);
        expect_beat("R6 R2 R3 read head", 64'h00001D0F_04000001, 1'b1, 1'b0);
        expect_beat("R6 R4 read tail", 64'h00000000_00000008, 1'b0, 1'b1);
        expect_idle("R6");
    endtask

    task automatic t_link_down;
        // R11: bus 3 unreachable with link down
        issue(1'b0, 8'h03, 8'h00, 12'h000, 2'b10, 32'h0);
        expect_refusal("R11 link down", 2'b10);
    endtask

    task automatic t_read_fwd_half;
        // R2 R5: 16-bit read on bus 1, offset 0x0E, forwarded kind
        link_l0 = 1'b1;
        issue(1'b0, 8'h01, 8'h08, 12'h00E, 2'b01, 32'h0);
        expect_beat("R2 R5 fwd read head", 64'h00001D0C_05000001, 1'b1, 1'b0);
        expect_beat("R4 fwd read tail", 64'h00000000_0108000C, 1'b0, 1'b1);
        expect_idle("R2");
    endtask

    task automatic t_write_aligned;
        // R7: dword write to quadword-aligned offset on bus 2
        issue(1'b1, 8'h02, 8'h10, 12'h020, 2'b10, 32'hCAFEF00D);
        expect_beat("R7 head", 64'h0000100F_45000001, 1'b1, 1'b0);
        expect_beat("R7 mid", 64'h00000000_02100020, 1'b0, 1'b0);
        expect_beat("R7 data", 64'h00000000_CAFEF00D, 1'b0, 1'b1);
        expect_idle("R7");
    endtask

    task automatic t_write_unaligned;
        // R8 R5: byte write offset 5, data lane 1
        issue(1'b1, 8'h00, 8'h00, 12'h005, 2'b00, 32'h123456AB);
        expect_beat("R8 R5 byte head", 64'h00001002_44000001, 1'b1, 1'b0);
        expect_beat("R8 R5 byte tail", 64'h0000AB00_00000004, 1'b0, 1'b1);
        expect_idle("R8");
        // R10 R8 R5: function 1 of device 0 accepted, 16-bit write offset 6
        issue(1'b1, 8'h00, 8'h01, 12'h006, 2'b01, 32'h9999BEEF);
        expect_beat("R10 R5 half head", 64'h0000100C_44000001, 1'b1, 1'b0);
        expect_beat("R8 R5 half tail", 64'hBEEF0000_00010004, 1'b0, 1'b1);
        expect_idle("R10");
    endtask

    task automatic t_filters;
        // R9: hidden base register
        issue(1'b0, 8'h00, 8'h00, 12'h010, 2'b10, 32'h0);
        expect_refusal("R9 hidden", 2'b01);
        // R10: device 1 on root bus
        issue(1'b1, 8'h00, 8'h08, 12'h004, 2'b10, 32'h5);
        expect_refusal("R10 device 1", 2'b10);
    endtask

    task automatic t_root_update;
        // R12: primary-bus write on root bus loads 0x03
        issue(1'b1, 8'h00, 8'h00, 12'h018, 2'b10, 32'h00050403);
        expect_beat("R12 head", 64'h0000100F_44000001, 1'b1, 1'b0);
        @(negedge clk);
        check(root_bus == 8'h00, "R12 not before last beat", {56'd0, root_bus}, 64'd0);
        check(tx_data == 64'h00000000_00000018, "R7 R12 mid", tx_data, 64'h00000000_00000018);
        expect_beat("R12 data", 64'h00000000_00050403, 1'b0, 1'b1);
        @(negedge clk);
        check(root_bus == 8'h03, "R12 root bus loaded", {56'd0, root_bus}, 64'd3);
        // R2 R3: bus 3 is now local, requester field follows
        issue(1'b0, 8'h03, 8'h00, 12'h000, 2'b10, 32'h0);
        expect_beat("R2 R3 new root head", 64'h03001D0F_04000001, 1'b1, 1'b0);
        expect_beat("R4 new root tail", 64'h00000000_03000000, 1'b0, 1'b1);
        expect_idle("R12");
        // R9 on the new root bus
        issue(1'b0, 8'h03, 8'h00, 12'h010, 2'b10, 32'h0);
        expect_refusal("R9 hidden new root", 2'b01);
        // R11: bus 0 is now downstream
        link_l0 = 1'b0;
        issue(1'b0, 8'h00, 8'h00, 12'h008, 2'b10, 32'h0);
        expect_refusal("R11 old root downstream", 2'b10);
        link_l0 = 1'b1;
        // R12: primary-bus write on another bus does not load
        issue(1'b1, 8'h04, 8'h00, 12'h018, 2'b10, 32'h00000077);
        expect_beat("R12 fwd head", 64'h0300100F_45000001, 1'b1, 1'b0);
        expect_beat("R12 fwd mid", 64'h00000000_04000018, 1'b0, 1'b0);
        expect_beat("R12 fwd data", 64'h00000000_00000077, 1'b0, 1'b1);
        @(negedge clk);
        check(root_bus == 8'h03, "R12 other bus ignored", {56'd0, root_bus}, 64'd3);
    endtask

    task automatic t_backpressure;
        // R13: sink stalls every beat
        tx_ready = 1'b0;
        issue(1'b0, 8'h03, 8'h00, 12'h004, 2'b10, 32'h0);
        for (int i = 0; i < 3; i++) begin
            expect_beat("R13 stalled head", 64'h03001D0F_04000001, 1'b1, 1'b0);
            check(req_ready == 1'b0, "R13 busy", {63'd0, req_ready}, 64'd0);
        end
        tx_ready = 1'b1;
        expect_beat("R13 tail after stall", 64'h00000000_03000004, 1'b0, 1'b1);
        expect_idle("R13");
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_read_local();
        t_link_down();
        t_read_fwd_half();
        t_write_aligned();
        t_write_unaligned();
        t_filters();
        t_root_update();
        t_backpressure();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule